// File: doc/BRIEF.md
# Waveform-Mode Timer Channel

This block is a single timer channel that runs in waveform mode. A 16-bit counter advances once per counting tick and follows one of four profiles: up-only, up-down, up-only with an automatic restart at the RC limit, or up-down with its turn-around at the RC limit. The counter is compared against three limit values, RA, RB and RC. Those compare hits, together with a software trigger and an edge-selected external event, drive two output pins, A and B. Each pin has a 2-bit action code per event source. With suitable codes the pins produce PWM or single-shot waveforms.

All behaviour comes from a 32-bit mode word. The limit registers and the command pulses (enable, disable, software trigger) arrive as ports from the surrounding register file. The counting tick comes from an external prescaler. The block reports the counter value, the pin levels, a run indication and a five-bit event pulse vector. The reset input is asynchronous and active low, and is expected to be released synchronously to the clock.

Top module: `tcw_channel`

## Requirements
- R1: After reset the counter reads 0, both pins read 0, the run indication is low and every status bit is 0.
- R2: The counter steps only in a clock cycle where `cnt_tick` is high, the channel runs and mode bit 15 is set. In profile 0 (mode[14:13]=0) it counts 0,1,2,… and the first step after a trigger loads 0.
- R3: In profile 2 the counter restarts from 0 on the step that follows its arrival at RC.
- R4: In profiles 1 and 3 the counter reverses from up to down on the step after it reaches its top, and from down to up on the step after it reaches 0. The top is RC in profile 3 and 0xFFFF in profile 1, and no overflow is flagged at the turn-around.
- R5: Action codes are 0 none, 1 set, 2 clear, 3 toggle. Pin A takes its actions from mode[17:16] (RA hit), [19:18] (RC hit), [21:20] (external event) and [23:22] (software trigger). Pin B takes them from [25:24] (RB hit), [27:26], [29:28] and [31:30]. A compare hit takes effect in the same edge on which the counter reaches the value.
- R6: When several events with a non-zero action reach one pin in the same cycle, the software trigger wins, then the external event, then the RC hit, then the RA/RB hit.
- R7: The external event is an edge on the line picked by mode[11:10] (0 pin B input, 1..3 external lines 0..2), with mode[9:8] selecting none, rising, falling or both. When mode[12] is set, the event is also a trigger. A trigger resets the counter to 0, counting up, on the next counting step and not before.
- R8: With mode[6] set, an RC hit stops counting until the next trigger. With mode[7] set, an RC hit disables the channel, and software or external triggers are then ignored until `cmd_en`. `cmd_dis` drops the run indication on the next edge.
- R9: When mode[11:10]=0, pin B is an input: `tiob_oe` is low and the pin B output level holds whatever its actions say.
- R10: The status vector pulses for one cycle, aligned with the counter update. Bit 0 marks a wrap from 0xFFFF to 0, and bits 2, 3 and 4 mark RA, RB and RC hits. Bit 1 stays 0.
- R11: With mode bit 15 clear, the counter and both pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 32 | Channel mode word |
| ra | input | 16 | Limit A |
| rb | input | 16 | Limit B |
| rc | input | 16 | Limit C |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse (wins over enable) |
| sw_trig | input | 1 | Software trigger pulse |
| cnt_tick | input | 1 | Counting clock enable from the prescaler |
| xc_in | input | 3 | External event lines 0..2 |
| tiob_in | input | 1 | Pin B level when used as input |
| cnt_val | output | 16 | Counter value |
| tioa | output | 1 | Pin A level |
| tiob_out | output | 1 | Pin B output level |
| tiob_oe | output | 1 | Pin B output enable |
| run | output | 1 | Channel enabled and not stopped |
| status | output | 5 | Event pulses: 0 wrap, 2 RA, 3 RB, 4 RC |

## Verification
The bench aims at the turn-around points. In profile 3 a counter that reversed one step late would overshoot RC, and in profile 1 a counter that wrapped instead of turning at 0xFFFF would report 0 and raise the wrap flag. It sets RA equal to RC so that an inverted priority leaves pin A set rather than cleared. It also fires a software trigger and an external edge in the same cycle, so a wrong winner shows up as the opposite pin level. Stop and disable are told apart by firing a trigger after the RC hit, since only the stopped channel may resume. An external trigger is sampled before the next tick, so a design that zeroed the counter at once would be caught.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    WV_UP        = 2'd0,
    WV_UPDN      = 2'd1,
    WV_UP_AUTO   = 2'd2,
    WV_UPDN_AUTO = 2'd3
  } wave_e;

  // mode word field positions (decoded by neighbouring software)
  localparam int MB_STOP   = 6;
  localparam int MB_DIS    = 7;
  localparam int MB_EDGE   = 8;
  localparam int MB_SRC    = 10;
  localparam int MB_ETRG   = 12;
  localparam int MB_WAVE   = 13;
  localparam int MB_WVON   = 15;
  localparam int MB_ACT_A  = 16;
  localparam int MB_ACT_B  = 24;
  localparam int N_SRC     = 4;   // event sources per pin

  function automatic logic act_apply(act_e a, logic cur);
    case (a)
      ACT_SET: act_apply = 1'b1;
      ACT_CLR: act_apply = 1'b0;
      ACT_TGL: act_apply = ~cur;
      default: act_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/tcw_counter.sv
module tcw_counter
  import tcw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         trig,
  input  wave_e        wave,
  input  logic [W-1:0] ra,
  input  logic [W-1:0] rb,
  input  logic [W-1:0] rc,
  output logic [W-1:0] cnt,
  output logic         cmp_a,
  output logic         cmp_b,
  output logic         cmp_c,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q, cnt_nxt, top;
  logic         dir_q, dir_nxt, pend_q, pend_d, wrap, updn;

  always_comb begin
    updn    = (wave == WV_UPDN) || (wave == WV_UPDN_AUTO);
    top     = (wave == WV_UPDN_AUTO) ? rc : CNT_MAX;
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    wrap    = 1'b0;
    if (pend_q) begin
      cnt_nxt = '0;
      dir_nxt = 1'b0;
    end else if (!dir_q) begin
      if (updn && cnt_q == top) begin
        dir_nxt = 1'b1;
        cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - ONE;
      end else begin
        cnt_nxt = cnt_q + ONE;
        wrap    = (cnt_q == CNT_MAX);
      end
    end else begin
      if (cnt_q == '0) begin
        dir_nxt = 1'b0;
        cnt_nxt = (top == '0) ? '0 : ONE;
      end else begin
        cnt_nxt = cnt_q - ONE;
      end
    end
  end

  // a trigger seen during a step waits for the following step
  assign pend_d = step ? trig : (pend_q | trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (step) begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
    end
  end

  assign cnt   = cnt_q;
  assign cmp_a = step & (cnt_nxt == ra);
  assign cmp_b = step & (cnt_nxt == rb);
  assign cmp_c = step & (cnt_nxt == rc);
  assign ovf   = step & wrap;

endmodule

// File: rtl/tcw_edge.sv
module tcw_edge #(
  parameter int NXC = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     src_sel,
  input  logic [1:0]     edge_sel,
  input  logic           tiob_in,
  input  logic [NXC-1:0] xc_in,
  output logic           evt
);
  logic [NXC:0] srcs;
  logic         cur, prev_q;

  assign srcs = {xc_in, tiob_in};
  assign cur  = srcs[src_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_comb begin
    case (edge_sel)
      2'd1:    evt = cur & ~prev_q;
      2'd2:    evt = ~cur & prev_q;
      2'd3:    evt = cur ^ prev_q;
      default: evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcw_outact.sv
module tcw_outact
  import tcw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [N_SRC-1:0]   ev,     // index 0 lowest priority
  input  logic [2*N_SRC-1:0] acts,
  output logic               pin
);
  logic pin_q, pin_nxt;

  always_comb begin
    pin_nxt = pin_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (ev[i] && act_e'(acts[2*i +: 2]) != ACT_NONE)
        pin_nxt = act_apply(act_e'(acts[2*i +: 2]), pin_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (upd_en) pin_q <= pin_nxt;
  end

  assign pin = pin_q;

endmodule

// File: rtl/tcw_channel.sv
module tcw_channel
  import tcw_pkg::*;
#(
  parameter int W   = 16,
  parameter int NXC = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    mode_cfg,
  input  logic [W-1:0]   ra,
  input  logic [W-1:0]   rb,
  input  logic [W-1:0]   rc,
  input  logic           cmd_en,
  input  logic           cmd_dis,
  input  logic           sw_trig,
  input  logic           cnt_tick,
  input  logic [NXC-1:0] xc_in,
  input  logic           tiob_in,
  output logic [W-1:0]   cnt_val,
  output logic           tioa,
  output logic           tiob_out,
  output logic           tiob_oe,
  output logic           run,
  output logic [4:0]     status
);
  logic       wave_on, b_is_in, en_q, en_d, stop_q, stop_d;
  logic       step, evt, sw_ok, ext_ok, usr_trig, trig;
  logic       cmp_a, cmp_b, cmp_c, ovf;
  logic [4:0] status_q;
  wave_e      wave;
  logic       unused_cfg;

  assign unused_cfg = ^mode_cfg[5:0];   // clock source fields live in the prescaler
  assign wave_on    = mode_cfg[MB_WVON];
  assign wave       = wave_e'(mode_cfg[MB_WAVE +: 2]);
  assign b_is_in    = (mode_cfg[MB_SRC +: 2] == 2'd0);

  tcw_edge #(.NXC(NXC)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .src_sel(mode_cfg[MB_SRC +: 2]), .edge_sel(mode_cfg[MB_EDGE +: 2]),
    .tiob_in(tiob_in), .xc_in(xc_in), .evt(evt)
  );

  assign sw_ok    = sw_trig & en_q & wave_on;
  assign ext_ok   = evt & en_q & wave_on;
  assign usr_trig = sw_ok | (ext_ok & mode_cfg[MB_ETRG]);
  assign step     = cnt_tick & en_q & ~stop_q & wave_on;
  assign trig     = usr_trig | ((wave == WV_UP_AUTO) & cmp_c);

  tcw_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .trig(trig), .wave(wave),
    .ra(ra), .rb(rb), .rc(rc), .cnt(cnt_val),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .ovf(ovf)
  );

  // run control next state
  always_comb begin
    en_d = en_q;
    if (cmd_dis)                            en_d = 1'b0;
    else if (cmd_en)                        en_d = 1'b1;
    else if (cmp_c && mode_cfg[MB_DIS])     en_d = 1'b0;

    stop_d = stop_q;
    if (cmd_en || usr_trig)                 stop_d = 1'b0;
    else if (cmp_c && mode_cfg[MB_STOP])    stop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      stop_q   <= 1'b0;
      status_q <= '0;
    end else begin
      en_q     <= en_d;
      stop_q   <= stop_d;
      status_q <= {cmp_c, cmp_b, cmp_a, 1'b0, ovf};
    end
  end

  tcw_outact u_pin_a (
    .clk(clk), .rst_n(rst_n), .upd_en(wave_on),
    .ev({sw_ok, ext_ok, cmp_c, cmp_a}),
    .acts(mode_cfg[MB_ACT_A +: 2*N_SRC]), .pin(tioa)
  );

  tcw_outact u_pin_b (
    .clk(clk), .rst_n(rst_n), .upd_en(wave_on & ~b_is_in),
    .ev({sw_ok, ext_ok, cmp_c, cmp_b}),
    .acts(mode_cfg[MB_ACT_B +: 2*N_SRC]), .pin(tiob_out)
  );

  assign tiob_oe = wave_on & ~b_is_in;
  assign run     = en_q & ~stop_q;
  assign status  = status_q;

endmodule

// File: rtl/tcw_channel_chk.sv
module tcw_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [31:0]  mode_cfg,
  input logic [W-1:0] ra,
  input logic [W-1:0] rc,
  input logic         cmd_dis,
  input logic         cnt_tick,
  input logic [W-1:0] cnt_val,
  input logic         tioa,
  input logic         tiob_out,
  input logic         run,
  input logic [4:0]   status
);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_cfg[15] && run && cnt_tick) |=> $stable(cnt_val)); // R2

  AST_CPA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> cnt_val == $past(ra)); // R5

  AST_DIS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !run); // R8

  AST_TIOB_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cfg[11:10] == 2'd0 && $past(mode_cfg[11:10]) == 2'd0) |-> $stable(tiob_out)); // R9

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> cnt_val == '0); // R10

  AST_CPC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |-> cnt_val == $past(rc)); // R10

  AST_NOWAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cfg[15] |=> ($stable(tioa) && $stable(tiob_out))); // R11

endmodule

bind tcw_channel tcw_channel_chk #(.W(W)) i_chk (.*);

// File: tb/test_tcw_channel.sv
module test_tcw_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mode_cfg;
  logic [15:0] ra, rb, rc;
  logic        cmd_en, cmd_dis, sw_trig, cnt_tick, tiob_in;
  logic [2:0]  xc_in;
  logic [15:0] cnt_val;
  logic        tioa, tiob_out, tiob_oe, run;
  logic [4:0]  status;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  tcw_channel i_tcw_channel (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .ra(ra), .rb(rb), .rc(rc),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .sw_trig(sw_trig), .cnt_tick(cnt_tick),
    .xc_in(xc_in), .tiob_in(tiob_in), .cnt_val(cnt_val), .tioa(tioa),
    .tiob_out(tiob_out), .tiob_oe(tiob_oe), .run(run), .status(status)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic [15:0] va, vb, vc, n, cnt;
    logic        a, b;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0909_8400, 16'd3, 16'd5, 16'd8, 16'd5,  16'd4, 1'b1, 1'b0},
    '{32'h0909_8400, 16'd3, 16'd5, 16'd8, 16'd7,  16'd6, 1'b1, 1'b1},
    '{32'h0909_8400, 16'd3, 16'd5, 16'd8, 16'd9,  16'd8, 1'b0, 1'b0},
    '{32'h0009_C400, 16'd2, 16'd9, 16'd4, 16'd8,  16'd2, 1'b1, 1'b0},
    '{32'h0009_C400, 16'd2, 16'd9, 16'd4, 16'd7,  16'd1, 1'b0, 1'b0},
    '{32'h0003_E400, 16'd2, 16'd9, 16'd4, 16'd7,  16'd2, 1'b0, 1'b0},
    '{32'h0003_E400, 16'd2, 16'd9, 16'd4, 16'd11, 16'd2, 1'b1, 1'b0},
    '{32'h0004_8440, 16'd9, 16'd9, 16'd3, 16'd8,  16'd3, 1'b1, 1'b0},
    '{32'h0004_8480, 16'd9, 16'd9, 16'd3, 16'd8,  16'd3, 1'b1, 1'b0},
    '{32'h0009_8400, 16'd3, 16'd9, 16'd3, 16'd4,  16'd3, 1'b0, 1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0:       vtag = "R2";
      1, 2:    vtag = "R5";
      3, 4:    vtag = "R3";
      5, 6:    vtag = "R4";
      7, 8:    vtag = "R8";
      default: vtag = "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_en = 0; cmd_dis = 0; sw_trig = 0; cnt_tick = 0;
    xc_in = '0; tiob_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [31:0] c, input logic [15:0] a, b, cc);
    mode_cfg = c; ra = a; rb = b; rc = cc;
  endtask

  task automatic pulse_en();
    cmd_en = 1'b1; @(negedge clk); cmd_en = 1'b0;
  endtask

  task automatic pulse_sw();
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2: watchdog expired, actual running expected finished");
    summary();
  end

  initial begin
    mode_cfg = '0; ra = '0; rb = '0; rc = '0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 cnt", 32'(cnt_val), 0);
    check("R1 pins", {30'd0, tioa, tiob_out}, 0);
    check("R1 run", 32'(run), 0);
    check("R1 status", 32'(status), 0);

    // table of profiles
    for (int i = 0; i < NV; i++) begin
      do_reset();
      setup(VECS[i].cfg, VECS[i].va, VECS[i].vb, VECS[i].vc);
      pulse_en();
      pulse_sw();
      ticks(int'(VECS[i].n));
      check({vtag(i), " cnt"}, 32'(cnt_val), 32'(VECS[i].cnt));
      check({vtag(i), " pin A"}, 32'(tioa), 32'(VECS[i].a));
      check({vtag(i), " pin B"}, 32'(tiob_out), 32'(VECS[i].b));
    end

    // R6 software trigger beats external event; R7 edge select
    do_reset();
    setup(32'h0060_8500, 16'd9, 16'd9, 16'd9);
    pulse_en();
    xc_in[0] = 1'b1; sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
    check("R6 sw over ext", 32'(tioa), 1);
    xc_in[0] = 1'b0; @(negedge clk);
    check("R7 falling ignored", 32'(tioa), 1);
    xc_in[0] = 1'b1; @(negedge clk);
    check("R7 rising clears", 32'(tioa), 0);

    // R7 external trigger waits for the next step
    do_reset();
    setup(32'h0000_9900, 16'h100, 16'h100, 16'h100);
    pulse_en(); pulse_sw(); ticks(6);
    check("R7 before trig", 32'(cnt_val), 5);
    xc_in[1] = 1'b1; @(negedge clk);
    check("R7 held until tick", 32'(cnt_val), 5);
    ticks(1);
    check("R7 restart", 32'(cnt_val), 0);

    // R8 stop resumes on trigger
    do_reset();
    setup(32'h0000_8440, 16'd9, 16'd9, 16'd3);
    pulse_en(); pulse_sw(); ticks(6);
    check("R8 stopped", 32'(run), 0);
    pulse_sw();
    check("R8 resumed", 32'(run), 1);
    ticks(2);
    check("R8 restart count", 32'(cnt_val), 1);
    // R8 disable ignores trigger
    do_reset();
    setup(32'h0000_8480, 16'd9, 16'd9, 16'd3);
    pulse_en(); pulse_sw(); ticks(6);
    pulse_sw(); ticks(2);
    check("R8 disabled run", 32'(run), 0);
    check("R8 disabled cnt", 32'(cnt_val), 3);
    pulse_en();
    cmd_dis = 1'b1; @(negedge clk); cmd_dis = 1'b0;
    check("R8 cmd_dis", 32'(run), 0);

    // R9 pin B as input
    do_reset();
    setup(32'h4000_8000, 16'd9, 16'd9, 16'd9);
    pulse_en(); pulse_sw();
    check("R9 oe low", 32'(tiob_oe), 0);
    check("R9 held", 32'(tiob_out), 0);
    mode_cfg = 32'h4000_8400;
    pulse_sw();
    check("R9 output mode", {30'd0, tiob_oe, tiob_out}, 3);

    // R11 waveform bit clear
    do_reset();
    setup(32'h0040_0400, 16'd1, 16'd1, 16'd1);
    pulse_en(); pulse_sw(); ticks(3);
    check("R11 cnt", 32'(cnt_val), 0);
    check("R11 pin A", 32'(tioa), 0);

    // R10 compare pulses
    do_reset();
    setup(32'h0000_8400, 16'd2, 16'd5, 16'd2);
    pulse_en(); pulse_sw(); ticks(3);
    check("R10 cmp pulse", 32'(status), 32'h14);
    @(negedge clk);
    check("R10 pulse clears", 32'(status), 0);

    // R10 wrap in profile 0
    do_reset();
    setup(32'h0000_8400, 16'h7000, 16'h7000, 16'h7000);
    pulse_en(); pulse_sw(); ticks(65537);
    check("R10 wrap cnt", 32'(cnt_val), 0);
    check("R10 wrap flag", 32'(status), 1);

    // R4 profile 1 turns at 0xFFFF
    do_reset();
    setup(32'h0000_A400, 16'h100, 16'h100, 16'h100);
    pulse_en(); pulse_sw(); ticks(65537);
    check("R4 top turn", 32'(cnt_val), 32'hFFFE);
    check("R4 no wrap", 32'(status[0]), 0);

    summary();
  end

endmodule